// File: doc/BRIEF.md
# I2C Target with Pointer-Addressed Register Bank

This block is a bus target for a two-wire serial bus. The bus runs at standard or fast rate and the block gives an external controller read and write access to a small bank of byte-wide registers. The serial clock and data lines are first brought into the system clock domain through flop synchronisers. A byte engine then recognises start, repeated-start and stop conditions. It checks the 7-bit device address and moves data bytes in either direction. The data line is open-drain. The block only ever asserts an output enable that pulls the line low.

In a write transfer, the first byte after the address sets a shared register pointer, and each later byte is stored at that pointer. In a read transfer, bytes are sent starting at the pointer. The pointer steps by one after every byte in either direction and wraps around the end of the bank. It keeps its value through a repeated start, so a controller sets the pointer with a short write and then reads from there.

All traffic arrives over the two bus wires, so no data stream crosses the block's edge. There is no valid/ready handshake and no back-pressure: the block never holds the clock line low. For this reason the system clock must run at least ten times faster than the bus clock.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset the data-line output enable `sda_oe` is 0, and it stays 0 until the block is addressed.
- R2: A falling data edge while the clock is high is a start. A rising data edge while the clock is high is a stop. A stop at any point, even in the middle of a byte, releases the data line and leaves the register pointer and the register contents unchanged.
- R3: The first byte after a start is seven address bits, MSB first, followed by a direction bit (1 = read, 0 = write). The block acknowledges by pulling the line low during the 9th clock only when the seven bits equal `DEV_ADDR`. If they differ, the block never drives the line and ignores all bytes until the next start, so no register changes.
- R4: In a write transfer, the first data byte loads the pointer with its low bits. Each later byte is acknowledged, stored at the pointer, and then the pointer steps by one.
- R5: In a read transfer, the block sends the register at the pointer MSB first, changing the line only while the clock is low. The pointer steps by one after each byte sent, including the last byte.
- R6: When the controller does not acknowledge a read byte, the block releases the data line and stays off the bus until the next start or stop.
- R7: A start does not change the pointer. A write that only sets the pointer, followed by a repeated start and a read, returns the register selected by that write.
- R8: The pointer wraps from register `NREGS-1` to register 0 during both write and read bursts. `NREGS` must be a power of two.
- R9: The block changes `sda_oe` only while the synchronised clock is low, except that it releases the line when it sees a start or a stop.
- R10: A register keeps its value until a write transfer stores a new byte at its index. Reset clears all registers to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 10x the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The hardest situations to reach from the pins are the ones where the bus stops in an unusual place. Examples are a stop arriving three bits into a data byte, and a controller that refuses a read byte and then keeps clocking. The bench uses a bit-level bus model whose tasks can end a transfer after any bit. It shows what the pointer held by starting a fresh read with no pointer byte, and it clocks an extra bit after the refusal to watch for any drive on the line. Wrap-around is reached with three-byte bursts that begin two registers below the end of the bank, both writing and reading.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_WR,
    ST_ACK_WR,
    ST_RD,
    ST_RD_ACK,
    ST_SKIP
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic [STAGES-1:0] stage_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        stage_q <= {stage_q[STAGES-2:0], din[i]};
        prev_q  <= stage_q[STAGES-1];
      end
    end

    assign dout[i] = stage_q[STAGES-1];
    assign rise[i] = stage_q[STAGES-1] & ~prev_q;
    assign fall[i] = ~stage_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
  parameter int unsigned NREGS = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem_q [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

  // R10: a stored byte is readable on the following cycle
  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h2A,
  parameter int unsigned NREGS    = 16,
  localparam int unsigned PW      = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PW-1:0]     rd_addr,
  output logic              wr_en,
  output logic [PW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);
  i2cs_state_e       state_q;
  logic [3:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [PW-1:0]     ptr_q;
  logic              ptr_load_q;
  logic              rw_q;
  logic              mack_q;
  logic              start_det;
  logic              stop_det;

  assign start_det = sda_fall & scl_lvl;
  assign stop_det  = sda_rise & scl_lvl;
  assign rd_addr   = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      ptr_q      <= '0;
      ptr_load_q <= 1'b0;
      rw_q       <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe     <= 1'b0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR: begin
            if (scl_rise && cnt_q != 4'd8) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (sh_q[7:1] == DEV_ADDR) begin
                  rw_q    <= sh_q[0];
                  sda_oe  <= 1'b1;
                  state_q <= ST_ACK_ADDR;
                end else begin
                  state_q <= ST_SKIP;
                end
              end else begin
                sda_oe  <= 1'b1;
                state_q <= ST_ACK_WR;
                if (ptr_load_q) begin
                  ptr_q      <= sh_q[PW-1:0];
                  ptr_load_q <= 1'b0;
                end else begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr_q;
                  wr_data <= sh_q;
                  ptr_q   <= ptr_q + 1'b1;
                end
              end
            end
          end
          ST_ACK_ADDR: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                sh_q    <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                state_q <= ST_RD;
              end else begin
                sda_oe     <= 1'b0;
                ptr_load_q <= 1'b1;
                state_q    <= ST_WR;
              end
            end
          end
          ST_ACK_WR: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              cnt_q   <= '0;
              state_q <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt_q == 4'd7) begin
                sda_oe  <= 1'b0;
                cnt_q   <= '0;
                ptr_q   <= ptr_q + 1'b1;
                state_q <= ST_RD_ACK;
              end else begin
                cnt_q  <= cnt_q + 4'd1;
                sda_oe <= ~sh_q[BYTE_W-2];
                sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack_q) begin
                sh_q    <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                state_q <= ST_RD;
              end else begin
                state_q <= ST_SKIP;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

  // R2: a stop always leaves the line released
  p_release_on_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R9: the drive moves only while the clock is low, or on a start/stop
  p_oe_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_lvl) || $past(start_det) || $past(stop_det)));

  // R3 / R6: no drive while traffic is being ignored
  p_quiet_when_skipping_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP || state_q == ST_IDLE) |-> !sda_oe);

  // R4: a stored byte is followed by a pointer one step further on
  p_ptr_step_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr_q == PW'(wr_addr + 1'b1)));

  // R7: a start leaves the pointer alone
  p_ptr_hold_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> $stable(ptr_q));

  // R10: stores happen only in write transfers
  p_store_only_in_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rw_q);
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2cs_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h2A,
  parameter int unsigned NREGS       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int unsigned PW      = $clog2(NREGS);
  localparam int unsigned IDX_SCL = 0;
  localparam int unsigned IDX_SDA = 1;

  logic [1:0]        lvl, rise, fall;
  logic              wr_en;
  logic [PW-1:0]     wr_addr, rd_addr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sda_i, scl_i}),
    .dout (lvl),
    .rise (rise),
    .fall (fall)
  );

  i2cs_engine #(.DEV_ADDR(DEV_ADDR), .NREGS(NREGS)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_lvl (lvl[IDX_SCL]),
    .scl_rise(rise[IDX_SCL]),
    .scl_fall(fall[IDX_SCL]),
    .sda_lvl (lvl[IDX_SDA]),
    .sda_rise(rise[IDX_SDA]),
    .sda_fall(fall[IDX_SDA]),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .sda_oe  (sda_oe)
  );

  i2cs_regfile #(.NREGS(NREGS), .DW(BYTE_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  // R1: nothing drives the line while reset is held
  p_released_in_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !sda_oe);
endmodule

// File: tb/i2c_regfile_slave_tb.sv
module i2c_regfile_slave_tb;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] model [16];

  always #2.5 clk = ~clk;

  i2c_regfile_slave #(.DEV_ADDR(DEV)) u_dut (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (m_scl),
    .sda_i (sda_line),
    .sda_oe(sda_oe)
  );

  // pointer, write data, expected read-back
  localparam logic [19:0] VEC [8] = '{
    {4'h0, 8'hA5, 8'hA5}, {4'h3, 8'h5A, 8'h5A},
    {4'h5, 8'hFF, 8'hFF}, {4'h7, 8'h01, 8'h01},
    {4'h9, 8'h80, 8'h80}, {4'hA, 8'h3C, 8'h3C},
    {4'hC, 8'hC3, 8'hC3}, {4'h1, 8'h7E, 8'h7E}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic wbit(input bit b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(2*Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic rbit(output bit b);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q);
    b = sda_line; tick(Q); m_scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit x;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(x);
    ack = !x;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit give_ack);
    bit x;
    for (int i = 7; i >= 0; i--) begin
      rbit(x);
      v[i] = x;
    end
    wbit(!give_ack);
  endtask

  task automatic write_one(input logic [3:0] p, input logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    bus_start();
    send_byte({DEV, 1'b0}, a0);
    send_byte({4'h0, p}, a1);
    send_byte(d, a2);
    bus_stop();
    ok = a0 & a1 & a2;
    model[p] = d;
  endtask

  task automatic read_one(input logic [3:0] p, output logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    bus_start();
    send_byte({DEV, 1'b0}, a0);
    send_byte({4'h0, p}, a1);
    bus_start();
    send_byte({DEV, 1'b1}, a2);
    recv_byte(d, 1'b0);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d1, d2;
    bit ok, a, x;
    bit seen_low;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;

    tick(5);
    check(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(20);
    check(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
    check(sda_line == 1'b1, "R1 line idle", sda_line, 1);

    // vector walk: write then pointer-write + repeated start + read (R4, R7, R10)
    foreach (VEC[k]) begin
      write_one(VEC[k][19:16], VEC[k][15:8], ok);
      check(ok, "R4 write acked", ok, 1);
      read_one(VEC[k][19:16], d, ok);
      check(ok && d == VEC[k][7:0], "R7 read after repeated start", d, VEC[k][7:0]);
    end

    // R3: wrong address, following bytes must be ignored
    seen_low = 1'b0;
    bus_start();
    send_byte({7'h15, 1'b0}, a);
    check(!a, "R3 no ack on wrong address", a, 0);
    send_byte(8'h03, a);
    if (a) seen_low = 1'b1;
    send_byte(8'hEE, a);
    if (a) seen_low = 1'b1;
    bus_stop();
    check(!seen_low, "R3 ignored bytes not acked", seen_low, 0);
    read_one(4'h3, d, ok);
    check(d == model[3], "R3 register untouched", d, model[3]);

    // R8/R4: burst write wrapping past the end
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h0E, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a);
    check(a, "R4 burst byte acked", a, 1);
    bus_stop();
    model[14] = 8'h11; model[15] = 8'h22; model[0] = 8'h33;

    // R5/R8: burst read wrapping, last byte refused (R6)
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h0E, a);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(d, 1'b1);
    recv_byte(d1, 1'b1);
    recv_byte(d2, 1'b0);
    check(d == 8'h11, "R5 burst byte 0", d, 8'h11);
    check(d1 == 8'h22, "R8 burst byte 1", d1, 8'h22);
    check(d2 == 8'h33, "R8 wrapped byte", d2, 8'h33);
    tick(4);
    check(sda_oe == 1'b0, "R6 released after refusal", sda_oe, 0);
    seen_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      rbit(x);
      if (!x) seen_low = 1'b1;
    end
    check(!seen_low, "R6 silent after refusal", seen_low, 0);
    bus_stop();

    // R5: pointer stepped past the refused byte, 14+3 wraps to 1
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(d, 1'b0);
    bus_stop();
    check(a && d == model[1], "R5 pointer after refused byte", d, model[1]);

    // R2: stop in the middle of a data byte
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'h05, a);
    wbit(1'b0); wbit(1'b1); wbit(1'b0);
    bus_stop();
    check(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(d, 1'b0);
    bus_stop();
    check(d == model[5], "R2 pointer and data kept over abort", d, model[5]);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule